// File: doc/BRIEF.md
# Static Memory Bank Access Sequencer

This block runs the pin timing for one bank of asynchronous static memory, such as SRAM, ROM or flash, on behalf of an internal requester. The requester holds a request (location address, write data, byte strobes, direction) valid until the block answers with a one-cycle ready pulse. For reads the pulse carries the sampled data, and for refused writes it carries an error flag. The block drives chip select, output enable, write enable, four active-low byte-lane selects, the location address and the write data. It samples the read data bus on the last clock of the read strobe.

A small configuration word sets the bank's behaviour. It holds the external data width, sequential-burst enable, write protection, chip-select polarity and the read-lane mode. Three 4-bit wait-state inputs set the strobe length of a first read, a sequential burst read and a write. A count of N gives a strobe of N+1 clocks. With burst enabled, a read to the location just after the previous one keeps chip select asserted and uses the short count. A read that lands on a multiple of four locations uses the first-read count again. The address is a location index: lanes are chosen from the width, and splitting wide transfers is left to the requester.

Top module: `smem_bank_seq`

## Requirements
- R1: After reset the configuration word reads back with the width field at its bank-dependent value (bank index 0, 4, 5 give code 10 = 32-bit; 2, 6 give 01 = 16-bit; 1, 3, 7 give 00 = 8-bit) and every other bit 0. Word layout: bits 1:0 width, bit 2 burst enable, bit 3 write protect, bit 4 chip select active high, bit 5 lanes held during reads, bits 7:6 reserved.
- R2: Bits 7:6 of the configuration word always read 0. A write whose width code is 11 leaves the width unchanged while the other fields still update.
- R3: Chip select is driven high when active if bit 4 is 1, and low when active if bit 4 is 0. Outside accesses it sits at the inactive level.
- R4: A non-burst read accepted from idle holds output enable low for ws_first+1 clocks. Ready rises ws_first+2 clocks after the request appears. Read data equals the memory bus at the last strobe clock, with lanes above the configured width returned as zero.
- R5: A write holds its strobe for ws_write+1 clocks with the request data on the data bus, and ready follows as for a read.
- R6: With burst enabled, a read of location previous+1 that is not a multiple of four keeps chip select asserted, uses ws_seq, and gets ready ws_seq+3 clocks after the request is presented during the previous ready pulse.
- R7: A sequential burst read whose location has its two low bits zero keeps chip select asserted but uses ws_first, giving ready ws_first+3 clocks after presentation.
- R8: With burst disabled, or for a non-sequential address, chip select goes inactive for at least one clock between accesses, and every read uses ws_first.
- R9: A write to a write-protected bank gives ready with the error flag for one clock, one clock after the request. It moves no strobe, lane select or chip select.
- R10: With bit 5 set, all four lane selects are low during reads. Writes pulse the write-enable pin low and drive the lane selects as the masked byte strobes.
- R11: With bit 5 clear, all lane selects are high during reads, the write-enable pin stays high, and the lane selects alone carry the write strobe.
- R12: During a write, lane selects go low only for strobed lanes that exist at the width: lane 0 for 8-bit, lanes 0-1 for 16-bit, all four for 32-bit.
- R13: Ready and error are single-cycle pulses, and error never appears without ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 8 | Configuration word write value |
| cfg_rdata | output | 8 | Configuration word current value |
| ws_first | input | 4 | Wait count for a first or quad-start read |
| ws_seq | input | 4 | Wait count for a sequential burst read |
| ws_write | input | 4 | Wait count for a write strobe |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Location address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte strobes |
| rsp_ready | output | 1 | Request completed (one cycle) |
| rsp_err | output | 1 | Write refused by protection (with ready) |
| rsp_rdata | output | DATA_W | Read data, upper unused lanes zero |
| mem_cs | output | 1 | Chip select, polarity from configuration |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bls_n | output | DATA_W/8 | Byte-lane selects, active low |
| mem_addr | output | ADDR_W | Location address to memory |
| mem_dout | output | DATA_W | Write data to memory |
| mem_dout_en | output | 1 | Data bus drive enable during writes |
| mem_din | input | DATA_W | Read data from memory |

## Verification
A wait counter that loads the wrong count shows within one access as a ready pulse early or late by a fixed number of clocks. It also shows as an output-enable or write-strobe window of the wrong length. A stale burst-open flag shows at once as chip select staying asserted between unrelated accesses, or dropping inside a burst. A wrong lane decode shows on the lane-select pins during the very strobe it affects. Protection faults show in the same clock as the error pulse.

// File: rtl/smem_pkg.sv
// Shared types and helpers for the static memory bank sequencer.
// Assumes four byte lanes at most (32-bit external bus).
package smem_pkg;

    // Configuration fields, bit 5 down to bit 0 of the configuration word.
    typedef struct packed {
        logic       rd_lanes;   // lane selects held low during reads
        logic       cs_high;    // chip select active high
        logic       wprot;      // bank refuses writes
        logic       burst;      // sequential quad-burst reads allowed
        logic [1:0] width;      // 00 8-bit, 01 16-bit, 10 32-bit, 11 reserved
    } smem_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACC    = 2'd1,
        ST_DONE   = 2'd2,
        ST_LINGER = 2'd3
    } smem_state_t;

    localparam logic [1:0] WID_8   = 2'b00;
    localparam logic [1:0] WID_16  = 2'b01;
    localparam logic [1:0] WID_32  = 2'b10;
    localparam logic [1:0] WID_RSV = 2'b11;

    // Number of existing byte lanes at a width code.
    function automatic int lane_count(input logic [1:0] w);
        case (w)
            WID_8:   return 1;
            WID_16:  return 2;
            default: return 4;
        endcase
    endfunction

    // Lane mask (four lanes) at a width code.
    function automatic logic [3:0] lane_mask(input logic [1:0] w);
        case (w)
            WID_8:   return 4'b0001;
            WID_16:  return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // Reset width code by bank index.
    function automatic logic [1:0] reset_width(input int idx);
        case (idx)
            1, 3, 7: return WID_8;
            2, 6:    return WID_16;
            default: return WID_32;
        endcase
    endfunction

endpackage

// File: rtl/smem_cfg_reg.sv
// Holds the bank configuration word.
// Assumes writes arrive only while the bank is idle; reserved width code
// writes keep the previous width, reserved bits are never stored.
module smem_cfg_reg
    import smem_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [5:0] wr_val,
    output smem_cfg_t  cfg
);
    localparam logic [1:0] RST_WIDTH = reset_width(BANK_IDX);

    // Register update with reserved-width filtering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{rd_lanes: 1'b0, cs_high: 1'b0, wprot: 1'b0,
                     burst: 1'b0, width: RST_WIDTH};
        end else if (wr_en) begin
            cfg.rd_lanes <= wr_val[5];
            cfg.cs_high  <= wr_val[4];
            cfg.wprot    <= wr_val[3];
            cfg.burst    <= wr_val[2];
            if (wr_val[1:0] != WID_RSV) begin
                cfg.width <= wr_val[1:0];
            end
        end
    end
endmodule

// File: rtl/smem_wait_ctr.sv
// Down-counter for strobe length. Loading N gives zero after N decrements,
// so a strobe state that leaves on zero lasts N+1 clocks.
module smem_wait_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load has priority; decrement saturates at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/smem_lane_ctl.sv
// Byte-lane select and write-enable decode.
// Assumes rd_act and wr_act are never both high.
module smem_lane_ctl #(
    parameter int LANES = 4
) (
    input  logic             rd_act,
    input  logic             wr_act,
    input  logic             rd_lanes,
    input  logic [LANES-1:0] lmask,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] bls_n,
    output logic             we_n
);
    // Lane selects: strobes on writes, mode-dependent level on reads.
    always_comb begin
        if (wr_act) begin
            bls_n = ~(be & lmask);
        end else if (rd_act && rd_lanes) begin
            bls_n = '0;
        end else begin
            bls_n = '1;
        end
    end

    // Dedicated write enable only used when lanes are held during reads.
    assign we_n = ~(wr_act && rd_lanes);
endmodule

// File: rtl/smem_bank_seq.sv
// Static memory bank access sequencer (top).
// Drives one asynchronous memory bank from a valid/ready request port.
// Assumes the requester holds a request until rsp_ready and may present the
// next one during the ready cycle; configuration changes only while idle.
module smem_bank_seq
    import smem_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 32,
    parameter int WS_W     = 4,
    parameter int BANK_IDX = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [7:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata,
    input  logic [WS_W-1:0]     ws_first,
    input  logic [WS_W-1:0]     ws_seq,
    input  logic [WS_W-1:0]     ws_write,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rsp_ready,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_cs,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [DATA_W/8-1:0] mem_bls_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dout,
    output logic                mem_dout_en,
    input  logic [DATA_W-1:0]   mem_din
);
    localparam int LANES = DATA_W / 8;

    smem_cfg_t          cfg;
    smem_state_t        st_q;
    logic               wr_q;
    logic               open_q;
    logic               err_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [LANES-1:0]   be_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [LANES-1:0]   lmask;
    logic [DATA_W-1:0]  dmask;
    logic               ctr_load;
    logic [WS_W-1:0]    ctr_val;
    logic               ctr_zero;
    logic               seq_hit;
    logic               quad_start;
    logic               wp_hit;
    logic               cs_act;
    logic               oe_act;
    logic               wr_act;
    logic               unused_rsv;

    assign unused_rsv = ^cfg_wdata[7:6];

    smem_cfg_reg #(.BANK_IDX(BANK_IDX)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_val (cfg_wdata[5:0]),
        .cfg    (cfg)
    );

    assign cfg_rdata = {2'b00, cfg};

    // Lane mask from width, widened to a data mask per lane.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lmask[i] = (i < lane_count(cfg.width));
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_dmask
            assign dmask[8*g +: 8] = {8{lmask[g]}};
        end
    endgenerate

    // Request classification against the open burst.
    assign seq_hit    = req_valid && !req_write && (req_addr == addr_q + 1'b1);
    assign quad_start = (req_addr[1:0] == 2'b00);
    assign wp_hit     = req_write && cfg.wprot;

    // Wait counter load selection per state.
    always_comb begin
        ctr_load = 1'b0;
        ctr_val  = '0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid && !wp_hit) begin
                    ctr_load = 1'b1;
                    ctr_val  = req_write ? ws_write : ws_first;
                end
            end
            ST_LINGER: begin
                if (seq_hit) begin
                    ctr_load = 1'b1;
                    ctr_val  = quad_start ? ws_first : ws_seq;
                end
            end
            default: ;
        endcase
    end

    smem_wait_ctr #(.W(WS_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .dec      (st_q == ST_ACC),
        .zero     (ctr_zero)
    );

    // Access state machine and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            wr_q    <= 1'b0;
            open_q  <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    open_q <= 1'b0;
                    if (req_valid) begin
                        wr_q    <= req_write;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        be_q    <= req_be;
                        err_q   <= wp_hit;
                        st_q    <= wp_hit ? ST_DONE : ST_ACC;
                    end
                end
                ST_ACC: begin
                    if (ctr_zero) begin
                        if (!wr_q) begin
                            rdata_q <= mem_din & dmask;
                        end
                        open_q <= !wr_q && cfg.burst;
                        st_q   <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    err_q <= 1'b0;
                    st_q  <= open_q ? ST_LINGER : ST_IDLE;
                end
                ST_LINGER: begin
                    if (seq_hit) begin
                        addr_q <= req_addr;
                        st_q   <= ST_ACC;
                    end else begin
                        open_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Strobe activity decoded from the registered state.
    assign cs_act = (st_q == ST_ACC) ||
                    (((st_q == ST_DONE) || (st_q == ST_LINGER)) && open_q);
    assign oe_act = cs_act && !wr_q;
    assign wr_act = (st_q == ST_ACC) && wr_q;

    smem_lane_ctl #(.LANES(LANES)) u_lanes (
        .rd_act   (oe_act),
        .wr_act   (wr_act),
        .rd_lanes (cfg.rd_lanes),
        .lmask    (lmask),
        .be       (be_q),
        .bls_n    (mem_bls_n),
        .we_n     (mem_we_n)
    );

    assign mem_cs      = cfg.cs_high ? cs_act : !cs_act;
    assign mem_oe_n    = !oe_act;
    assign mem_addr    = addr_q;
    assign mem_dout    = wdata_q;
    assign mem_dout_en = wr_act;
    assign rsp_ready   = (st_q == ST_DONE);
    assign rsp_err     = (st_q == ST_DONE) && err_q;
    assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/smem_bank_seq_chk.sv
// Port-level property checker for the bank sequencer, bound to the top.
module smem_bank_seq_chk
    import smem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       rsp_ready,
    input logic       rsp_err,
    input logic       mem_cs,
    input logic       mem_oe_n,
    input logic       mem_we_n,
    input logic [3:0] mem_bls_n,
    input logic       mem_dout_en
);
    AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:6] == 2'b00); // R2
    AST_OE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_cs == cfg_rdata[4])); // R3
    AST_ERR_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_ready); // R13
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready); // R13
    AST_WP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (mem_we_n && (&mem_bls_n) && !mem_dout_en
                     && (mem_cs != cfg_rdata[4]))); // R9
    AST_NO_WE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n); // R10
    AST_RD_LANES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && !cfg_rdata[5]) |-> (&mem_bls_n)); // R11
    AST_WR_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> ((~mem_bls_n & ~lane_mask(cfg_rdata[1:0])) == 4'b0000)); // R12
endmodule

bind smem_bank_seq smem_bank_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rdata   (cfg_rdata),
    .rsp_ready   (rsp_ready),
    .rsp_err     (rsp_err),
    .mem_cs      (mem_cs),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_bls_n   (mem_bls_n),
    .mem_dout_en (mem_dout_en)
);

// File: tb/smem_bank_seq_tb.sv
// Self-checking bench for the static memory bank sequencer.
module smem_bank_seq_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  ws_first = '0, ws_seq = '0, ws_write = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_ready, rsp_err;
    logic [31:0] rsp_rdata;
    logic        mem_cs, mem_oe_n, mem_we_n, mem_dout_en;
    logic [3:0]  mem_bls_n;
    logic [19:0] mem_addr;
    logic [31:0] mem_dout, mem_din;

    logic [7:0]  b3_rdata;
    logic        b3_rdy, b3_err, b3_cs, b3_oe, b3_we, b3_den;
    logic [3:0]  b3_bls;
    logic [19:0] b3_addr;
    logic [31:0] b3_rd, b3_dout;

    int n_chk = 0, n_err = 0;
    int stb_cnt = 0, we_cnt = 0, csa_cnt = 0, csi_cnt = 0;
    logic [3:0]  stb_bls = '1, rd_bls = '1;
    logic [31:0] stb_dout = '0;
    logic        cs_pol = 1'b0;
    logic [31:0] got_rd;
    logic        got_err;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] mem_model(input logic [19:0] a);
        return {a[7:0] ^ 8'h44, a[7:0] ^ 8'h33, a[7:0] ^ 8'h22, a[7:0] ^ 8'h11};
    endfunction

    function automatic logic [31:0] wmask(input logic [1:0] w);
        return (w == 2'b00) ? 32'h0000_00FF : (w == 2'b01) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    assign mem_din = mem_model(mem_addr);

    smem_bank_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ws_first(ws_first), .ws_seq(ws_seq),
        .ws_write(ws_write), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_bls_n(mem_bls_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    smem_bank_seq #(.BANK_IDX(3)) dut_b3 (
        .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_wdata(8'h00),
        .cfg_rdata(b3_rdata), .ws_first(4'h0), .ws_seq(4'h0),
        .ws_write(4'h0), .req_valid(1'b0), .req_write(1'b0),
        .req_addr(20'h0), .req_wdata(32'h0), .req_be(4'h0),
        .rsp_ready(b3_rdy), .rsp_err(b3_err), .rsp_rdata(b3_rd),
        .mem_cs(b3_cs), .mem_oe_n(b3_oe), .mem_we_n(b3_we),
        .mem_bls_n(b3_bls), .mem_addr(b3_addr), .mem_dout(b3_dout),
        .mem_dout_en(b3_den), .mem_din(32'h0)
    );

    // Pin monitor: cumulative counts sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n || mem_dout_en) stb_cnt++;
            if (!mem_we_n) we_cnt++;
            if (mem_cs == cs_pol) csa_cnt++; else csi_cnt++;
            if (mem_dout_en) begin stb_bls = mem_bls_n; stb_dout = mem_dout; end
            if (!mem_oe_n) rd_bls = mem_bls_n;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
        cs_pol = v[4];
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic access(input logic wr, input logic [19:0] a, input logic [31:0] d,
                          input logic [3:0] be, output int lat);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        lat = 0;
        forever begin
            tick();
            lat++;
            if (rsp_ready) break;
        end
        got_rd = rsp_rdata;
        got_err = rsp_err;
        req_valid = 1'b0;
    endtask

    typedef struct packed {
        logic       wr;
        logic [7:0] cfg;
        logic [3:0] ws;
        logic [3:0] be;
        logic [3:0] exp_bls;
        logic       exp_we;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 8'h02, 4'd2, 4'h0, 4'hF, 1'b0},   // 32-bit read, lanes high  R11
        '{1'b0, 8'h21, 4'd0, 4'h0, 4'h0, 1'b0},   // 16-bit read, lanes held  R10
        '{1'b1, 8'h02, 4'd3, 4'hA, 4'h5, 1'b0},   // 32-bit write via lanes    R11
        '{1'b1, 8'h21, 4'd1, 4'hF, 4'hC, 1'b1},   // 16-bit write, WE pin      R10 R12
        '{1'b1, 8'h00, 4'd0, 4'h7, 4'hE, 1'b0},   // 8-bit write, one lane     R12
        '{1'b0, 8'h20, 4'd5, 4'h0, 4'h0, 1'b0},   // 8-bit read, lanes held    R10
        '{1'b1, 8'h22, 4'd2, 4'h5, 4'hA, 1'b1}    // 32-bit write, WE pin      R10
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int lat, s0, w0, a0, i0;
        logic [19:0] adr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // Reset state
        chk("R1 cfg reset bank0", {24'h0, cfg_rdata}, 32'h02);
        chk("R1 cfg reset bank3", {24'h0, b3_rdata}, 32'h00);
        chk("R3 idle cs low-pol", {31'h0, mem_cs}, 32'h1);
        chk("R13 idle ready", {31'h0, rsp_ready}, 32'h0);
        chk("R11 idle lanes", {28'h0, mem_bls_n}, 32'hF);
        // Reserved handling
        set_cfg(8'hFF);
        chk("R2 width 11 ignored", {24'h0, cfg_rdata}, 32'h3E);
        set_cfg(8'hC1);
        chk("R2 reserved bits", {24'h0, cfg_rdata}, 32'h01);

        // Vector table walk (non-burst)
        foreach (VECS[k]) begin
            set_cfg(VECS[k].cfg);
            ws_first = VECS[k].ws; ws_write = VECS[k].ws;
            adr = 20'h00040 + 20'(k * 5);
            s0 = stb_cnt; w0 = we_cnt;
            access(VECS[k].wr, adr, 32'hA5C3_0000 + k, VECS[k].be, lat);
            chk(VECS[k].wr ? "R5 write latency" : "R4 read latency", lat, VECS[k].ws + 2);
            chk(VECS[k].wr ? "R5 strobe length" : "R4 oe length", stb_cnt - s0, VECS[k].ws + 1);
            if (VECS[k].wr) begin
                chk("R12 write lanes", {28'h0, stb_bls}, {28'h0, VECS[k].exp_bls});
                chk("R5 write data", stb_dout, 32'hA5C3_0000 + k);
                chk("R10 R11 we pin use", we_cnt - w0, VECS[k].exp_we ? VECS[k].ws + 1 : 0);
            end else begin
                chk("R10 R11 read lanes", {28'h0, rd_bls}, {28'h0, VECS[k].exp_bls});
                chk("R4 read data", got_rd, mem_model(adr) & wmask(VECS[k].cfg[1:0]));
            end
            idle(2);
        end

        // Burst with quad restart
        set_cfg(8'h06);
        ws_first = 4'd4; ws_seq = 4'd1;
        access(1'b0, 20'h00101, 32'h0, 4'h0, lat);
        chk("R4 burst first latency", lat, 6);
        i0 = csi_cnt;
        access(1'b0, 20'h00102, 32'h0, 4'h0, lat);
        chk("R6 seq latency", lat, 4);
        chk("R6 seq data", got_rd, mem_model(20'h00102));
        access(1'b0, 20'h00103, 32'h0, 4'h0, lat);
        chk("R6 seq latency 2", lat, 4);
        access(1'b0, 20'h00104, 32'h0, 4'h0, lat);
        chk("R7 quad restart latency", lat, 7);
        access(1'b0, 20'h00105, 32'h0, 4'h0, lat);
        chk("R6 after quad latency", lat, 4);
        chk("R6 R7 cs held in burst", csi_cnt - i0, 0);
        // Burst enabled, non-sequential
        access(1'b0, 20'h00110, 32'h0, 4'h0, lat);
        chk("R8 nonseq latency", lat, 8);
        chk("R8 cs gap nonseq", (csi_cnt - i0) >= 1, 1);
        idle(3);

        // Burst disabled, sequential addresses
        set_cfg(8'h02);
        ws_first = 4'd2; ws_seq = 4'd0;
        access(1'b0, 20'h00200, 32'h0, 4'h0, lat);
        chk("R8 first latency", lat, 4);
        i0 = csi_cnt;
        access(1'b0, 20'h00201, 32'h0, 4'h0, lat);
        chk("R8 no-burst latency", lat, 5);
        chk("R8 cs gap", (csi_cnt - i0) >= 1, 1);
        idle(2);

        // Write protection
        set_cfg(8'h0A);
        s0 = stb_cnt; w0 = we_cnt; a0 = csa_cnt;
        access(1'b1, 20'h00300, 32'hDEAD_BEEF, 4'hF, lat);
        chk("R9 wp latency", lat, 1);
        chk("R9 wp error", {31'h0, got_err}, 32'h1);
        chk("R9 wp no strobe", stb_cnt - s0, 0);
        chk("R9 wp no we", we_cnt - w0, 0);
        chk("R9 wp no cs", csa_cnt - a0, 0);
        tick();
        chk("R13 ready single", {30'h0, rsp_ready, rsp_err}, 32'h0);
        access(1'b0, 20'h00300, 32'h0, 4'h0, lat);
        chk("R9 wp read allowed", {31'h0, got_err}, 32'h0);
        chk("R9 wp read data", got_rd, mem_model(20'h00300));
        idle(2);

        // Chip select active high
        set_cfg(8'h12);
        ws_first = 4'd1;
        tick();
        chk("R3 idle cs high-pol", {31'h0, mem_cs}, 32'h0);
        a0 = csa_cnt;
        access(1'b0, 20'h00400, 32'h0, 4'h0, lat);
        chk("R3 cs active clocks", csa_cnt - a0, 2);
        idle(2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule